// File: doc/BRIEF.md
# Seconds Counter, 00 to 59 in Packed BCD

This block keeps a seconds count as two decimal digits: a four-bit BCD ones digit and a three-bit tens digit. On every one-second tick the count moves forward by one. After 59 it returns to 00 on the same clock edge as any other step. The return is made by the synchronous next-state logic, so no asynchronous clear is involved and the tens digit never briefly shows 6. A single-cycle minute-carry pulse lets a second stage of the same kind count minutes.

The block is clocked directly by a 32.768 kHz reference. A two-stage prescaler divides that reference by 128 and then by 256 to make the one-second tick. A mode input can instead take the tick from an external single-cycle enable. Both divider moduli are parameters, so a fast bench or a different reference can use other values.

Top module: `sec_counter`

## Requirements
- R1: On each clock edge where the selected tick is high, the ones digit goes from v to v+1 for v below 9, and from 9 to 0.
- R2: The ones digit `ones` is plain binary-coded decimal, bits [3:0], and never holds a value above 9.
- R3: The tens digit `tens` advances only on a tick edge while `ones` is 9. From 5 it returns to 0 together with the ones digit, so 59 is followed by 00. It never holds a value above 5.
- R4: On an edge without a tick, both digits keep their values.
- R5: `min_carry` is high for exactly the one cycle that follows the tick edge moving the count from 59 to 00, and is low at every other time.
- R6: While `rst` is high at a clock edge, both digits become 0, `min_carry` becomes 0 and the prescaler is cleared. After `rst` falls, the first internal tick comes on the (DIV_LO*DIV_HI)-th edge.
- R7: With `use_ext` = 0, the tick comes from the prescaler once every DIV_LO*DIV_HI clock edges (128*256 by default), and `ext_tick` has no effect.
- R8: With `use_ext` = 1, `ext_tick` is the tick and the prescaler output has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, nominally 32.768 kHz |
| rst | input | 1 | Synchronous reset, active high |
| use_ext | input | 1 | 1: count `ext_tick`; 0: count the internal divided tick |
| ext_tick | input | 1 | External one-cycle advance enable |
| ones | output | 4 | Ones digit, BCD 0..9 |
| tens | output | 3 | Tens digit, 0..5 |
| min_carry | output | 1 | One-cycle pulse after the 59 to 00 step |

## Verification
Several properties are checked on every cycle: both digit ranges, the hold when no tick is present, the single-step advance of the ones digit, the timing and uniqueness of the minute carry, and the reset values. The exact period of the internal divider, the clearing of the prescaler phase by reset, and the way the mode input hides one tick source from the other can only be shown by the bench scenarios. Those scenarios count edges from reset and drive the unused tick source while the other mode is selected. The bench also runs more than two full minutes through a reference model with mixed tick and idle cycles, and compares every digit pair against it.

// File: rtl/sec_cnt_pkg.sv
package sec_cnt_pkg;

  localparam int unsigned ONES_MOD = 10;
  localparam int unsigned TENS_MOD = 6;
  localparam int unsigned ONES_W   = 4;
  localparam int unsigned TENS_W   = 3;

  // width of a counter that must hold 0..mod-1
  function automatic int unsigned cnt_width(input int unsigned mod);
    return (mod > 2) ? $clog2(mod) : 1;
  endfunction

  // next value of a modulo counter
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned mod);
    return ((v + 1) >= mod) ? 0 : v + 1;
  endfunction

  // true when a counter sits on its last value
  function automatic logic at_last(input int unsigned v, input int unsigned mod);
    return (v == mod - 1);
  endfunction

endpackage

// File: rtl/mod_counter.sv
module mod_counter
  import sec_cnt_pkg::*;
#(
  parameter int unsigned MOD = 10,
  parameter int unsigned W   = cnt_width(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] val,
  output logic         last,
  output logic         roll
);

  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst)      val_q <= '0;
    else if (adv) val_q <= W'(wrap_inc(int'(val_q), MOD));
  end

  assign val  = val_q;
  assign last = at_last(int'(val_q), MOD);
  assign roll = adv & last;

endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
  import sec_cnt_pkg::*;
#(
  parameter int unsigned DIV_LO = 128,
  parameter int unsigned DIV_HI = 256
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int unsigned LO_W = cnt_width(DIV_LO);
  localparam int unsigned HI_W = cnt_width(DIV_HI);

  logic [LO_W-1:0] lo_val;
  logic [HI_W-1:0] hi_val;
  logic            lo_last, lo_roll;
  logic            hi_last, hi_roll;

  mod_counter #(.MOD(DIV_LO), .W(LO_W)) u_lo (
    .clk(clk), .rst(rst), .adv(1'b1),
    .val(lo_val), .last(lo_last), .roll(lo_roll)
  );

  mod_counter #(.MOD(DIV_HI), .W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .adv(lo_roll),
    .val(hi_val), .last(hi_last), .roll(hi_roll)
  );

  assign tick = hi_roll;

endmodule

// File: rtl/sec_digits.sv
module sec_digits
  import sec_cnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [ONES_W-1:0] ones,
  output logic [TENS_W-1:0] tens,
  output logic              minute_roll
);

  logic ones_last, ones_roll;
  logic tens_last, tens_roll;

  mod_counter #(.MOD(ONES_MOD), .W(ONES_W)) u_ones (
    .clk(clk), .rst(rst), .adv(tick),
    .val(ones), .last(ones_last), .roll(ones_roll)
  );

  mod_counter #(.MOD(TENS_MOD), .W(TENS_W)) u_tens (
    .clk(clk), .rst(rst), .adv(ones_roll),
    .val(tens), .last(tens_last), .roll(tens_roll)
  );

  assign minute_roll = tens_roll;

endmodule

// File: rtl/sec_counter.sv
module sec_counter
  import sec_cnt_pkg::*;
#(
  parameter int unsigned DIV_LO = 128,
  parameter int unsigned DIV_HI = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        use_ext,
  input  logic        ext_tick,
  output logic [3:0]  ones,
  output logic [2:0]  tens,
  output logic        min_carry
);

  logic div_tick;
  logic sec_tick;
  logic minute_roll;
  logic carry_q;

  sec_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
    .clk(clk), .rst(rst), .tick(div_tick)
  );

  assign sec_tick = use_ext ? ext_tick : div_tick;

  sec_digits u_dig (
    .clk(clk), .rst(rst), .tick(sec_tick),
    .ones(ones), .tens(tens), .minute_roll(minute_roll)
  );

  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else     carry_q <= minute_roll;
  end

  assign min_carry = carry_q;

endmodule

// File: rtl/sec_counter_chk.sv
module sec_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       sec_tick,
  input logic [3:0] ones,
  input logic [2:0] tens,
  input logic       min_carry
);

  p_ones_bcd_r2: assert property (@(posedge clk) disable iff (rst)
    ones <= 4'd9);

  p_tens_range_r3: assert property (@(posedge clk) disable iff (rst)
    tens <= 3'd5);

  p_ones_step_r1: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && ones != 4'd9) |=> (ones == $past(ones) + 4'd1));

  p_ones_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && ones == 4'd9) |=> (ones == 4'd0));

  p_tens_only_at_nine_r3: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && ones != 4'd9) |=> $stable(tens));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> ($stable(ones) && $stable(tens)));

  p_carry_fires_r5: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && ones == 4'd9 && tens == 3'd5) |=> min_carry);

  p_carry_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
    min_carry |-> (ones == 4'd0 && tens == 3'd0));

  p_carry_single_r5: assert property (@(posedge clk) disable iff (rst)
    min_carry |=> !min_carry);

  p_reset_r6: assert property (@(posedge clk)
    rst |=> (ones == 4'd0 && tens == 3'd0 && !min_carry));

endmodule

bind sec_counter sec_counter_chk u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick),
  .ones(ones), .tens(tens), .min_carry(min_carry)
);

// File: tb/sim_sec_counter.sv
`timescale 1ns/1ps
module sim_sec_counter;

  localparam int unsigned T_LO = 4;
  localparam int unsigned T_HI = 2;
  localparam int unsigned PERIOD = T_LO * T_HI;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       use_ext = 1'b1;
  logic       ext_tick = 1'b0;
  logic [3:0] ones;
  logic [2:0] tens;
  logic       min_carry;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sec_counter #(.DIV_LO(T_LO), .DIV_HI(T_HI)) u0 (
    .clk(clk), .rst(rst), .use_ext(use_ext), .ext_tick(ext_tick),
    .ones(ones), .tens(tens), .min_carry(min_carry)
  );

  // vector: {tick, tens[2:0], ones[3:0], carry}
  localparam logic [8:0] VEC [13] = '{
    {1'b1, 3'd0, 4'd1, 1'b0}, {1'b0, 3'd0, 4'd1, 1'b0},
    {1'b1, 3'd0, 4'd2, 1'b0}, {1'b1, 3'd0, 4'd3, 1'b0},
    {1'b0, 3'd0, 4'd3, 1'b0}, {1'b1, 3'd0, 4'd4, 1'b0},
    {1'b1, 3'd0, 4'd5, 1'b0}, {1'b1, 3'd0, 4'd6, 1'b0},
    {1'b1, 3'd0, 4'd7, 1'b0}, {1'b1, 3'd0, 4'd8, 1'b0},
    {1'b1, 3'd0, 4'd9, 1'b0}, {1'b1, 3'd1, 4'd0, 1'b0},
    {1'b0, 3'd1, 4'd0, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // inputs change at a falling edge; one rising edge; return at next falling edge
  task automatic cyc(input logic t);
    ext_tick = t;
    @(posedge clk);
    @(negedge clk);
    ext_tick = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(1'b0);
    rst = 1'b0;
  endtask

  initial begin
    int m;
    @(negedge clk);
    cyc(1'b1);
    rst = 1'b0;
    check("R6 reset ones", ones, 0);
    check("R6 reset tens", tens, 0);
    check("R6 reset carry", min_carry, 0);

    // table walk (external tick mode)
    for (int i = 0; i < 13; i++) begin
      cyc(VEC[i][8]);
      check("R1 table ones", ones, int'(VEC[i][4:1]));
      check("R3 table tens", tens, int'(VEC[i][7:5]));
      check("R4 table carry", min_carry, int'(VEC[i][0]));
    end

    // more than two minutes against a model, mixed tick and idle cycles
    m = 10;
    for (int i = 0; i < 300; i++) begin
      logic t;
      int exp_c;
      t = (i % 4) != 3;
      exp_c = 0;
      cyc(t);
      if (t) begin
        exp_c = (m == 59) ? 1 : 0;
        m = (m + 1) % 60;
      end
      check("R1 R2 run ones", ones, m % 10);
      check("R3 R4 run tens", tens, m / 10);
      check("R5 run carry", min_carry, exp_c);
    end

    // R8: external mode, no ext_tick for longer than several divider periods
    for (int i = 0; i < 3 * PERIOD; i++) cyc(1'b0);
    check("R8 divider ignored ones", ones, m % 10);
    check("R8 divider ignored tens", tens, m / 10);

    // R6: reset mid-count
    do_reset();
    check("R6 mid reset ones", ones, 0);
    check("R6 mid reset tens", tens, 0);
    check("R6 mid reset carry", min_carry, 0);

    // R7 and R6: internal divider, ext_tick held high and ignored
    use_ext = 1'b0;
    do_reset();
    for (int i = 1; i < int'(PERIOD); i++) cyc(1'b1);
    check("R7 no tick before period", ones, 0);
    cyc(1'b1);
    check("R6 R7 first tick at period", ones, 1);
    for (int i = 1; i < int'(PERIOD); i++) cyc(1'b1);
    check("R7 hold inside period", ones, 1);
    cyc(1'b0);
    check("R7 second tick", ones, 2);
    for (int i = 0; i < 58 * int'(PERIOD) - 1; i++) cyc(1'b0);
    check("R7 ones at 59", ones, 9);
    check("R7 tens at 59", tens, 5);
    check("R5 no carry before wrap", min_carry, 0);
    cyc(1'b0);
    check("R3 wrap ones", ones, 0);
    check("R3 wrap tens", tens, 0);
    check("R5 divider carry", min_carry, 1);
    cyc(1'b0);
    check("R5 carry one cycle", min_carry, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule